// File: doc/BRIEF.md
# I2C Register Write Target

This block is an I2C target that lets a bus master load a bank of 8-bit control registers. Both bus lines are sampled with the system clock through a short synchronizer. START and STOP conditions are recognised on the synchronized lines. After a START, the block compares the first byte with a hard-wired 7-bit device address and a write direction bit. If they match, the next byte selects a register index. Every byte after the index is data.

Each accepted byte is acknowledged by pulling SDA low for the ninth clock. Each data byte lands in the register at the current index, and the index then steps forward by one. Past the last register, the index wraps to register zero.

The whole bank is presented as one flat parallel output, which the surrounding logic uses as static configuration. A one-cycle update pulse carries the index and value of each write. SDA is driven only as an active-low pull enable, so the pad logic can build an open-drain output.

Top module: `i2c_reg_target`

## Requirements
- R1: While reset is high and in the first cycle after it, every register reads zero, `sdaPullN` is 1 (SDA released) and `wrStrobe` is 0.
- R2: SDA falling while SCL is high (START) begins address reception. SDA rising while SCL is high (STOP) returns the block to idle with SDA released.
- R3: A first byte equal to address 0x12 (7 bits, MSB first) followed by a 0 direction bit is acknowledged: `sdaPullN` is 0 throughout the high phase of the ninth SCL clock. `sdaPullN` only changes while SCL is low.
- R4: A first byte with a different address, or with direction bit 1 (read), gets no acknowledge. All later bytes are then neither acknowledged nor written until the next START or STOP.
- R5: The byte after an accepted address is the register index and is acknowledged. Only its low 6 bits select the register; bits 7 and 6 are ignored.
- R6: Each data byte is acknowledged and written to the register at the current index. Register i appears on `regFlat[8*i+7:8*i]`. In the same cycle, `wrStrobe` pulses for exactly one cycle, with `wrAddr` set to the index and `wrData` set to the byte.
- R7: After each data byte, the index advances by one, so a burst fills consecutive registers.
- R8: A burst that writes register 0x3F continues at register 0x00, overwriting its earlier contents.
- R9: A repeated START in the middle of a transfer discards the partial transfer. The next byte is treated as a device address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| sclIn | input | 1 | SCL line as seen at the pad |
| sdaIn | input | 1 | SDA line as seen at the pad |
| sdaPullN | output | 1 | Active-low SDA pull enable (0 = pull SDA low) |
| regFlat | output | 512 | Register bank, register i in bits 8*i+7 down to 8*i |
| wrStrobe | output | 1 | One-cycle pulse per register update |
| wrAddr | output | 6 | Index of the register being updated |
| wrData | output | 8 | Value being written |

## Verification
Two functions can fall in the same cycle: the write of a data byte to register 0x3F and the wrap of the index back to zero. A burst that starts at index 0x3E pushes three data bytes through that boundary. A scoreboard then checks that the strobed indices read 0x3E, 0x3F, 0x00 in order. A second case puts a repeated START where a data byte would follow an index. It is judged by where the next burst lands and by the final contents of the whole bank compared with a model.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_INDEX,
    PH_DATA,
    PH_SKIP
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadIndex;
    logic       writeData;
    logic [7:0] byteVal;
  } dpCmd_t;

endpackage

// File: rtl/i2c_reg_ctrl.sv
module i2c_reg_ctrl
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h12,
  parameter int         SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   sclIn,
  input  logic   sdaIn,
  output dpCmd_t cmd,
  output logic   sdaPullN,
  output logic   sclSync,
  output logic   stopSeen
);

  localparam int BITS_PER_BYTE = 8;
  localparam int CNT_W = $clog2(BITS_PER_BYTE + 1);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclP, sdaP;
  logic sclRise, sclFall, startEv, stopEv;

  phase_t     phase;
  logic [CNT_W-1:0] bitCnt;
  logic [7:0] shiftReg;
  logic       inAck;
  logic       ackOn;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclP    <= sclS;
      sdaP    <= sdaS;
    end
  end

  assign sclS    = sclPipe[SYNC_STAGES-1];
  assign sdaS    = sdaPipe[SYNC_STAGES-1];
  assign sclRise = sclS & ~sclP;
  assign sclFall = ~sclS & sclP;
  assign startEv = sclS & sclP & sdaP & ~sdaS;
  assign stopEv  = sclS & sclP & ~sdaP & sdaS;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      bitCnt   <= '0;
      shiftReg <= '0;
      inAck    <= 1'b0;
      ackOn    <= 1'b0;
      cmd      <= '0;
    end else begin
      cmd.loadIndex <= 1'b0;
      cmd.writeData <= 1'b0;
      if (startEv) begin
        phase  <= PH_ADDR;
        bitCnt <= '0;
        inAck  <= 1'b0;
        ackOn  <= 1'b0;
      end else if (stopEv) begin
        phase  <= PH_IDLE;
        bitCnt <= '0;
        inAck  <= 1'b0;
        ackOn  <= 1'b0;
      end else if (phase inside {PH_ADDR, PH_INDEX, PH_DATA}) begin
        if (sclRise && !inAck && bitCnt != CNT_W'(BITS_PER_BYTE)) begin
          shiftReg <= {shiftReg[6:0], sdaS};
          bitCnt   <= bitCnt + 1'b1;
        end else if (sclFall) begin
          if (inAck) begin
            inAck  <= 1'b0;
            ackOn  <= 1'b0;
            bitCnt <= '0;
          end else if (bitCnt == CNT_W'(BITS_PER_BYTE)) begin
            unique case (phase)
              PH_ADDR: begin
                if (shiftReg == {DEV_ADDR, 1'b0}) begin
                  ackOn <= 1'b1;
                  inAck <= 1'b1;
                  phase <= PH_INDEX;
                end else begin
                  phase <= PH_SKIP;
                end
              end
              PH_INDEX: begin
                ackOn         <= 1'b1;
                inAck         <= 1'b1;
                cmd.loadIndex <= 1'b1;
                cmd.byteVal   <= shiftReg;
                phase         <= PH_DATA;
              end
              default: begin
                ackOn         <= 1'b1;
                inAck         <= 1'b1;
                cmd.writeData <= 1'b1;
                cmd.byteVal   <= shiftReg;
              end
            endcase
          end
        end
      end
    end
  end

  assign sdaPullN = ~ackOn;
  assign sclSync  = sclS;
  assign stopSeen = stopEv;

endmodule

// File: rtl/i2c_reg_datapath.sv
module i2c_reg_datapath
  import i2c_reg_pkg::*;
#(
  parameter int NREG = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  dpCmd_t                   cmd,
  output logic [NREG*8-1:0]        regFlat,
  output logic                     wrStrobe,
  output logic [$clog2(NREG)-1:0]  wrAddr,
  output logic [7:0]               wrData
);

  localparam int IDXW = $clog2(NREG);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NREG - 1);

  logic [NREG-1:0][7:0] bank;
  logic [IDXW-1:0]      index;
  logic [IDXW-1:0]      nextIdx;

  assign nextIdx = (index == LAST_IDX) ? '0 : index + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank     <= '0;
      index    <= '0;
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      wrStrobe <= cmd.writeData;
      if (cmd.loadIndex) begin
        index <= cmd.byteVal[IDXW-1:0];
      end
      if (cmd.writeData) begin
        bank[index] <= cmd.byteVal;
        wrAddr      <= index;
        wrData      <= cmd.byteVal;
        index       <= nextIdx;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regFlat[g*8 +: 8] = bank[g];
  end

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h12,
  parameter int         NREG     = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sclIn,
  input  logic                    sdaIn,
  output logic                    sdaPullN,
  output logic [NREG*8-1:0]       regFlat,
  output logic                    wrStrobe,
  output logic [$clog2(NREG)-1:0] wrAddr,
  output logic [7:0]              wrData
);

  dpCmd_t cmd;
  logic   sclSync;
  logic   stopSeen;

  i2c_reg_ctrl #(
    .DEV_ADDR   (DEV_ADDR),
    .SYNC_STAGES(2)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .cmd     (cmd),
    .sdaPullN(sdaPullN),
    .sclSync (sclSync),
    .stopSeen(stopSeen)
  );

  i2c_reg_datapath #(
    .NREG(NREG)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .regFlat (regFlat),
    .wrStrobe(wrStrobe),
    .wrAddr  (wrAddr),
    .wrData  (wrData)
  );

endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
  parameter int NREG = 64
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    sdaPullN,
  input logic [NREG*8-1:0]       regFlat,
  input logic                    wrStrobe,
  input logic [$clog2(NREG)-1:0] wrAddr,
  input logic [7:0]              wrData,
  input logic                    sclSync,
  input logic                    stopSeen
);

  // R1
  rst_release_chk: assert property (@(posedge clk)
    $fell(rst) |-> (sdaPullN && !wrStrobe));

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stopSeen |=> sdaPullN);

  // R3
  ack_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (sclSync && $past(sclSync)) |-> $stable(sdaPullN));

  // R6
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wrStrobe |=> !wrStrobe);

  // R6
  wr_bank_chk: assert property (@(posedge clk) disable iff (rst)
    wrStrobe |-> (regFlat[{wrAddr, 3'b000} +: 8] == wrData));

endmodule

bind i2c_reg_target i2c_reg_target_chk #(.NREG(NREG)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .sdaPullN(sdaPullN),
  .regFlat (regFlat),
  .wrStrobe(wrStrobe),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .sclSync (sclSync),
  .stopSeen(stopSeen)
);

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;

  localparam int NREG = 64;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclLine = 1'b1;
  logic sdaM = 1'b1;
  logic sdaPullN;
  logic [NREG*8-1:0] regFlat;
  logic wrStrobe;
  logic [5:0] wrAddr;
  logic [7:0] wrData;
  logic sdaBus;

  assign sdaBus = sdaM & sdaPullN;

  always #5 clk = ~clk;

  i2c_reg_target i_i2c_reg_target (
    .clk     (clk),
    .rst     (rst),
    .sclIn   (sclLine),
    .sdaIn   (sdaBus),
    .sdaPullN(sdaPullN),
    .regFlat (regFlat),
    .wrStrobe(wrStrobe),
    .wrAddr  (wrAddr),
    .wrData  (wrData)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [13:0] expQ[$];
  logic [7:0] model [NREG];

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && wrStrobe) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6 unexpected write", {18'd0, wrAddr, wrData}, 32'd0);
      end else begin
        logic [13:0] e;
        e = expQ.pop_front();
        check({wrAddr, wrData} == e, "R6/R7/R8 write addr+data",
              {18'd0, wrAddr, wrData}, {18'd0, e});
      end
    end
  end

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ();
    sclLine = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclLine = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    sclLine = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ();
      sclLine = 1'b1; waitQ(); waitQ();
      sclLine = 1'b0; waitQ();
    end
    sdaM = 1'b1; waitQ();
    sclLine = 1'b1; waitQ();
    acked = (sdaBus == 1'b0);
    waitQ();
    sclLine = 1'b0; waitQ();
  endtask

  task automatic expectWrite(input logic [5:0] a, input logic [7:0] d);
    expQ.push_back({a, d});
    model[a] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ak;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    repeat (4) @(negedge clk);
    // R1 during reset
    check(regFlat == '0, "R1 bank zero", 32'(|regFlat), 32'd0);
    check(sdaPullN == 1'b1, "R1 sda released", 32'(sdaPullN), 32'd1);
    rst = 1'b0;
    @(negedge clk);
    check(wrStrobe == 1'b0, "R1 no strobe", 32'(wrStrobe), 32'd0);
    waitQ();

    // single write: index 0x05 <- 0xA5
    busStart();
    sendByte(8'h24, ak); check(ak, "R3 address ack", 32'(ak), 32'd1);
    sendByte(8'h05, ak); check(ak, "R5 index ack", 32'(ak), 32'd1);
    expectWrite(6'h05, 8'hA5);
    sendByte(8'hA5, ak); check(ak, "R6 data ack", 32'(ak), 32'd1);
    busStop();
    waitQ();
    check(sdaPullN == 1'b1, "R2 released after stop", 32'(sdaPullN), 32'd1);

    // burst through the top of the bank: R7, R8
    busStart();
    sendByte(8'h24, ak); check(ak, "R3 address ack", 32'(ak), 32'd1);
    sendByte(8'h3E, ak); check(ak, "R5 index ack", 32'(ak), 32'd1);
    expectWrite(6'h3E, 8'h11);
    sendByte(8'h11, ak); check(ak, "R7 data ack", 32'(ak), 32'd1);
    expectWrite(6'h3F, 8'h22);
    sendByte(8'h22, ak); check(ak, "R7 data ack", 32'(ak), 32'd1);
    expectWrite(6'h00, 8'h33);
    sendByte(8'h33, ak); check(ak, "R8 wrap data ack", 32'(ak), 32'd1);
    busStop();
    waitQ();
    check(regFlat[0 +: 8] == 8'h33, "R8 reg0 after wrap", 32'(regFlat[0 +: 8]), 32'h33);

    // index byte with top bits set: R5
    busStart();
    sendByte(8'h24, ak);
    sendByte(8'hC7, ak); check(ak, "R5 index ack high bits", 32'(ak), 32'd1);
    expectWrite(6'h07, 8'h5C);
    sendByte(8'h5C, ak);
    busStop();
    waitQ();
    check(regFlat[7*8 +: 8] == 8'h5C, "R5 masked index", 32'(regFlat[7*8 +: 8]), 32'h5C);

    // wrong address: R4
    busStart();
    sendByte(8'h26, ak); check(!ak, "R4 wrong address nack", 32'(ak), 32'd0);
    sendByte(8'h01, ak); check(!ak, "R4 ignored index", 32'(ak), 32'd0);
    sendByte(8'h99, ak); check(!ak, "R4 ignored data", 32'(ak), 32'd0);
    busStop();
    waitQ();
    check(regFlat[1*8 +: 8] == 8'h00, "R4 reg1 untouched", 32'(regFlat[1*8 +: 8]), 32'h00);

    // read direction: R4, then recovery by START
    busStart();
    sendByte(8'h25, ak); check(!ak, "R4 read bit nack", 32'(ak), 32'd0);
    sendByte(8'h02, ak); check(!ak, "R4 ignored after read", 32'(ak), 32'd0);
    busStart();
    sendByte(8'h24, ak); check(ak, "R4 recovery on start", 32'(ak), 32'd1);
    sendByte(8'h30, ak);
    expectWrite(6'h30, 8'h42);
    sendByte(8'h42, ak);
    busStop();
    waitQ();

    // repeated start mid transfer: R9
    busStart();
    sendByte(8'h24, ak);
    sendByte(8'h0A, ak);
    busStart();
    sendByte(8'h24, ak); check(ak, "R9 address after repeated start", 32'(ak), 32'd1);
    sendByte(8'h14, ak); check(ak, "R9 index after repeated start", 32'(ak), 32'd1);
    expectWrite(6'h14, 8'h6D);
    sendByte(8'h6D, ak);
    expectWrite(6'h15, 8'h6E);
    sendByte(8'h6E, ak);
    busStop();
    waitQ();
    check(regFlat[10*8 +: 8] == 8'h00, "R9 reg 0x0A untouched", 32'(regFlat[10*8 +: 8]), 32'h00);

    // end of run
    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R6 all writes seen", 32'(expQ.size()), 32'd0);
    for (int i = 0; i < NREG; i++) begin
      check(regFlat[i*8 +: 8] == model[i], "R6 bank contents",
            32'(regFlat[i*8 +: 8]), 32'(model[i]));
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule